// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block runs external memory accesses over a 16-bit bus that carries the low address half and the data on the same wires. Each access is a fixed sequence of bus states: an address state (T1), a data state (T2), any number of wait states (TW) and a closing state (T3). Outside an access the bus is idle. The block generates the address latch strobe, the data strobe, the read/write status, the two active-low byte-lane enables and a write strobe for the low byte lane. Pad buffers appear as output-enable signals rather than tri-state drivers.

On the internal side a single request carries an address, an access size (byte, half word or word), a direction, write data and the number of wait states. The block answers with read data and a one-cycle completion pulse. An external master can claim the bus through an asynchronous, active-low hold request. The block finishes any access in flight, floats the address, data and control outputs, and answers with an active-low acknowledge. No new access starts until the bus is handed back.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: An accepted request (`req_valid` and `req_ready` high at a rising edge) runs T1 in the next cycle, then T2, then exactly `req_waits` TW cycles, then T3. `done` is high for exactly the T3 cycle.
- R2: The size codes are 0 = byte, 1 = half word, 2 and 3 = word. For half word and word, `uben_n`=0, `lben_n`=0 and `ad_o[0]`=0 in T1. For a byte at an even address, `uben_n`=1, `lben_n`=0 and `ad_o[0]`=0. For a byte at an odd address, `uben_n`=0, `lben_n`=1 and `ad_o[0]`=1. In T1, `ad_o[15:1]` shows address bits 15..1 and `addr_hi_o` shows the bits above 15.
- R3: The byte enables, `addr_hi_o` and the address placed on `ad_o` in T1 change only at the rising edge that begins T1. They keep their values while the bus is idle.
- R4: `rw_o` is 1 for a read and 0 for a write from T1 through T3. It is 1 in every other state.
- R5: `astb_n` goes low at the falling edge in T1 and returns high at the falling edge in T3. It is high whenever no access is running.
- R6: `dstb_n` is low in T2 and in every TW cycle, and high in all other cycles.
- R7: `wrl_n` is low in T2 and TW only for a write whose `lben_n` is 0. It stays high for reads and for writes to an odd byte.
- R8: `rd_data` holds the value of `ad_i` taken at the rising edge that begins T3. Later changes on `ad_i` do not alter it, and it is valid while `done` is high.
- R9: `hold_req_n` passes through a two-flop synchronizer. When the bus is idle, `hold_ack_n` falls three rising edges after `hold_req_n` goes low. During an access, it falls at the edge that ends T3. While `hold_ack_n` is 0, `ctrl_oe` and `ad_oe` are 0.
- R10: While a hold is granted, `req_ready` is 0 and no T1 starts. When `hold_req_n` returns high, `hold_ack_n` rises and the outputs are driven again for at least one clock before the next T1.
- R11: In T2, TW and T3 of a write, `ad_o` carries `req_wdata` with `ad_oe`=1. In the same states of a read, `ad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Internal access request |
| req_ready | output | 1 | Request accepted at this edge when high |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 half word, 2/3 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 16 | Write data |
| req_waits | input | WAIT_W | Number of wait states |
| rd_data | output | 16 | Read data captured at T3 entry |
| done | output | 1 | High during T3 |
| ad_i | input | 16 | Multiplexed bus, inbound value |
| ad_o | output | 16 | Multiplexed bus, outbound value |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| addr_hi_o | output | ADDR_W-16 | Upper address bits |
| ctrl_oe | output | 1 | Drive enable for strobes, status, enables and upper address |
| astb_n | output | 1 | Address latch strobe, active low |
| dstb_n | output | 1 | Data strobe, active low |
| rw_o | output | 1 | 1 read, 0 write |
| uben_n | output | 1 | Upper byte lane enable, active low |
| lben_n | output | 1 | Lower byte lane enable, active low |
| wrl_n | output | 1 | Low-lane write strobe, active low |
| hold_req_n | input | 1 | Asynchronous bus hold request, active low |
| hold_ack_n | output | 1 | Bus hold acknowledge, active low |

## Verification
The hardest case to reach is a hold request that arrives in the middle of a long access. The bus must then finish the access with every strobe timed correctly and go straight from T3 into the released state, with no idle cycle in between. The bench reaches it by lowering `hold_req_n` during T1 of an access with three wait states. The synchronizer delay therefore runs out inside the wait states. The bench then checks that the next state after T3 floats the bus. It also holds a request off while the bus is released and confirms that the first T1 comes only after a driven cycle with the acknowledge high.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_HOLD = 3'd5,
        ST_PRE  = 3'd6
    } bus_state_e;

    typedef struct packed {
        logic ube_n;
        logic lbe_n;
        logic a0;
    } lane_sel_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;

    function automatic lane_sel_t lane_decode(input logic [1:0] size, input logic a0);
        lane_sel_t r;
        if (size == SZ_BYTE) begin
            r.ube_n = ~a0;
            r.lbe_n = a0;
            r.a0    = a0;
        end else begin
            r.ube_n = 1'b0;
            r.lbe_n = 1'b0;
            r.a0    = 1'b0;
        end
        return r;
    endfunction

    function automatic logic strobe_phase(input bus_state_e s);
        return (s == ST_T2) || (s == ST_TW);
    endfunction

    function automatic logic data_phase(input bus_state_e s);
        return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
    endfunction

    function automatic logic in_access(input bus_state_e s);
        return (s == ST_T1) || data_phase(s);
    endfunction

endpackage

// File: rtl/mbus_hold_sync.sv
module mbus_hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic hold_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_n};
    end

    assign hold_o = ~chain[STAGES-1];
endmodule

// File: rtl/mbus_lane_dec.sv
module mbus_lane_dec
    import mbus_pkg::*;
(
    input  logic [1:0] size,
    input  logic       a0,
    output lane_sel_t  lanes
);
    always_comb lanes = lane_decode(size, a0);
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_s,
    input  logic              req_valid,
    input  logic [ADDR_W-1:1] req_addr_hi,
    input  lane_sel_t         req_lanes,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WAIT_W-1:0] req_waits,
    input  logic [DATA_W-1:0] ad_i,
    output logic              req_ready,
    output bus_state_e        state,
    output logic [ADDR_W-1:1] addr_q,
    output lane_sel_t         lanes_q,
    output logic              write_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_data
);
    bus_state_e        nxt;
    logic [WAIT_W-1:0] wcnt;
    logic              accept;

    assign req_ready = ((state == ST_IDLE) || (state == ST_PRE) || (state == ST_T3)) && !hold_s;
    assign accept    = req_valid && req_ready;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_PRE: begin
                if (hold_s)         nxt = ST_HOLD;
                else if (req_valid) nxt = ST_T1;
            end
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = (wcnt == '0) ? ST_T3 : ST_TW;
            ST_TW:   nxt = (wcnt == WAIT_W'(1)) ? ST_T3 : ST_TW;
            ST_T3: begin
                if (hold_s)         nxt = ST_HOLD;
                else if (req_valid) nxt = ST_T1;
                else                nxt = ST_IDLE;
            end
            ST_HOLD: if (!hold_s) nxt = ST_PRE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            wcnt    <= '0;
            addr_q  <= '0;
            lanes_q <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            rd_data <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                addr_q  <= req_addr_hi;
                lanes_q <= req_lanes;
                write_q <= req_write;
                wdata_q <= req_wdata;
                wcnt    <= req_waits;
            end else if (state == ST_TW) begin
                wcnt <= wcnt - WAIT_W'(1);
            end
            if (strobe_phase(state) && (nxt == ST_T3) && !write_q)
                rd_data <= ad_i;
        end
    end
endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    localparam int HI_W  = ADDR_W - 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_state_e        state,
    input  logic [ADDR_W-1:1] addr_q,
    input  lane_sel_t         lanes_q,
    input  logic              write_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic              ctrl_oe,
    output logic              astb_n,
    output logic              dstb_n,
    output logic              rw_o,
    output logic              uben_n,
    output logic              lben_n,
    output logic              wrl_n,
    output logic              hold_ack_n,
    output logic              done
);
    logic released;
    logic astb_q;

    assign released = (state == ST_HOLD);

    // address strobe runs on the falling edge: low from mid-T1 to mid-T3
    always_ff @(negedge clk) begin
        if (rst) astb_q <= 1'b1;
        else     astb_q <= !((state == ST_T1) || strobe_phase(state));
    end

    assign astb_n     = astb_q;
    assign dstb_n     = !strobe_phase(state);
    assign wrl_n      = !(strobe_phase(state) && write_q && !lanes_q.lbe_n);
    assign rw_o       = in_access(state) ? !write_q : 1'b1;
    assign uben_n     = lanes_q.ube_n;
    assign lben_n     = lanes_q.lbe_n;
    assign addr_hi_o  = addr_q[ADDR_W-1:16];
    assign ad_o       = data_phase(state) ? wdata_q : {addr_q[15:1], lanes_q.a0};
    assign ad_oe      = !released && !(data_phase(state) && !write_q);
    assign ctrl_oe    = !released;
    assign hold_ack_n = !released;
    assign done       = (state == ST_T3);
endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    input  logic [WAIT_W-1:0] req_waits,
    output logic [15:0]       rd_data,
    output logic              done,
    input  logic [15:0]       ad_i,
    output logic [15:0]       ad_o,
    output logic              ad_oe,
    output logic [ADDR_W-17:0] addr_hi_o,
    output logic              ctrl_oe,
    output logic              astb_n,
    output logic              dstb_n,
    output logic              rw_o,
    output logic              uben_n,
    output logic              lben_n,
    output logic              wrl_n,
    input  logic              hold_req_n,
    output logic              hold_ack_n
);
    logic              hold_s;
    lane_sel_t         req_lanes;
    lane_sel_t         lanes_q;
    bus_state_e        state;
    logic [ADDR_W-1:1] addr_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;

    mbus_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_n(hold_req_n), .hold_o(hold_s)
    );

    mbus_lane_dec u_dec (
        .size(req_size), .a0(req_addr[0]), .lanes(req_lanes)
    );

    mbus_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_seq (
        .clk(clk), .rst(rst), .hold_s(hold_s),
        .req_valid(req_valid), .req_addr_hi(req_addr[ADDR_W-1:1]),
        .req_lanes(req_lanes), .req_write(req_write),
        .req_wdata(req_wdata), .req_waits(req_waits), .ad_i(ad_i),
        .req_ready(req_ready), .state(state), .addr_q(addr_q),
        .lanes_q(lanes_q), .write_q(write_q), .wdata_q(wdata_q),
        .rd_data(rd_data)
    );

    mbus_pins #(.ADDR_W(ADDR_W)) u_pins (
        .clk(clk), .rst(rst), .state(state), .addr_q(addr_q),
        .lanes_q(lanes_q), .write_q(write_q), .wdata_q(wdata_q),
        .ad_o(ad_o), .ad_oe(ad_oe), .addr_hi_o(addr_hi_o),
        .ctrl_oe(ctrl_oe), .astb_n(astb_n), .dstb_n(dstb_n),
        .rw_o(rw_o), .uben_n(uben_n), .lben_n(lben_n), .wrl_n(wrl_n),
        .hold_ack_n(hold_ack_n), .done(done)
    );
endmodule

// File: rtl/mbus_cycle_chk.sv
module mbus_cycle_chk #(
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            done,
    input logic            ad_oe,
    input logic [HI_W-1:0] addr_hi_o,
    input logic            ctrl_oe,
    input logic            astb_n,
    input logic            dstb_n,
    input logic            rw_o,
    input logic            uben_n,
    input logic            lben_n,
    input logic            wrl_n,
    input logic            hold_ack_n
);
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_astb_close_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(astb_n) |-> done);

    p_lane_pair_r2: assert property (@(posedge clk) disable iff (rst)
        !(uben_n && lben_n));

    p_lane_keep_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid && req_ready) |-> $stable({uben_n, lben_n, addr_hi_o}));

    p_dstb_inside_r5: assert property (@(posedge clk) disable iff (rst)
        !dstb_n |-> !astb_n);

    p_wrl_write_r7: assert property (@(posedge clk) disable iff (rst)
        !wrl_n |-> (!rw_o && !dstb_n && !lben_n));

    p_hold_float_r9: assert property (@(posedge clk) disable iff (rst)
        !hold_ack_n |-> (!ctrl_oe && !ad_oe && dstb_n && rw_o));

    p_hold_stall_r10: assert property (@(posedge clk) disable iff (rst)
        !hold_ack_n |-> !req_ready);

    p_read_float_r11: assert property (@(posedge clk) disable iff (rst)
        (!dstb_n && rw_o) |-> !ad_oe);
endmodule

bind mbus_cycle_ctrl mbus_cycle_chk #(.HI_W(ADDR_W - 16)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .ad_oe(ad_oe), .addr_hi_o(addr_hi_o), .ctrl_oe(ctrl_oe),
    .astb_n(astb_n), .dstb_n(dstb_n), .rw_o(rw_o), .uben_n(uben_n),
    .lben_n(lben_n), .wrl_n(wrl_n), .hold_ack_n(hold_ack_n)
);

// File: tb/sim_mbus_cycle_ctrl.sv
module sim_mbus_cycle_ctrl;
    localparam int ADDR_W = 24;
    localparam int WAIT_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic              req_write = 1'b0;
    logic [15:0]       req_wdata = '0;
    logic [WAIT_W-1:0] req_waits = '0;
    logic [15:0]       rd_data;
    logic              done;
    logic [15:0]       ad_i = '0;
    logic [15:0]       ad_o;
    logic              ad_oe;
    logic [ADDR_W-17:0] addr_hi_o;
    logic              ctrl_oe, astb_n, dstb_n, rw_o, uben_n, lben_n, wrl_n;
    logic              hold_req_n = 1'b1;
    logic              hold_ack_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mbus_cycle_ctrl #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .req_waits(req_waits), .rd_data(rd_data),
        .done(done), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
        .addr_hi_o(addr_hi_o), .ctrl_oe(ctrl_oe), .astb_n(astb_n),
        .dstb_n(dstb_n), .rw_o(rw_o), .uben_n(uben_n), .lben_n(lben_n),
        .wrl_n(wrl_n), .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n)
    );

    function automatic logic [2:0] exp_lanes(input logic [1:0] sz, input logic a0);
        if (sz == 2'd0) return a0 ? 3'b011 : 3'b100;
        return 3'b000;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_access(input logic [ADDR_W-1:0] addr, input logic [1:0] sz,
                             input logic wr, input logic [15:0] wd,
                             input logic [WAIT_W-1:0] nw, input logic [15:0] bus_rd,
                             input bit hold_mid);
        logic [2:0]  ln;
        logic [15:0] abus;
        bit          wrl_exp;
        ln      = exp_lanes(sz, addr[0]);
        abus    = {addr[15:1], ln[0]};
        wrl_exp = wr && !ln[1];
        req_addr = addr; req_size = sz; req_write = wr; req_wdata = wd; req_waits = nw;
        req_valid = 1'b1;
        check(req_ready == 1'b1, "R10 ready before access", 32'(req_ready), 32'd1);
        tick();
        req_valid = 1'b0;
        ad_i = bus_rd;
        if (hold_mid) hold_req_n = 1'b0;
        // T1
        check({uben_n, lben_n, ad_o[0]} == ln, "R2 lane table", 32'({uben_n, lben_n, ad_o[0]}), 32'(ln));
        check(ad_o == abus && addr_hi_o == addr[ADDR_W-1:16] && ad_oe, "R2 address in T1",
              {addr_hi_o, ad_o}, {addr[ADDR_W-1:16], abus});
        check(rw_o == !wr, "R4 rw in T1", 32'(rw_o), 32'(!wr));
        check(dstb_n == 1'b1 && done == 1'b0, "R6 T1 dstb idle", {dstb_n, done}, 32'b10);
        @(negedge clk); #1;
        check(astb_n == 1'b0, "R5 astb low mid T1", 32'(astb_n), 32'd0);
        for (int i = 0; i <= int'(nw); i++) begin
            tick();
            check(dstb_n == 1'b0 && done == 1'b0, "R1 R6 T2/TW strobe", {dstb_n, done}, 32'b00);
            check(wrl_n == !wrl_exp, "R7 low-lane write strobe", 32'(wrl_n), 32'(!wrl_exp));
            check(ad_oe == wr && (!wr || ad_o == wd), "R11 data drive", {ad_oe, ad_o}, {wr, wd});
            check(astb_n == 1'b0 && rw_o == !wr, "R5 R4 astb/rw held", {astb_n, rw_o}, {1'b0, !wr});
        end
        tick();
        ad_i = ~bus_rd;
        // T3
        check(done == 1'b1 && dstb_n == 1'b1 && wrl_n == 1'b1, "R1 R6 T3", {done, dstb_n, wrl_n}, 32'b111);
        check(astb_n == 1'b0 && rw_o == !wr, "R5 R4 T3 start", {astb_n, rw_o}, {1'b0, !wr});
        check(ad_oe == wr, "R11 T3 drive", 32'(ad_oe), 32'(wr));
        if (!wr) check(rd_data == bus_rd, "R8 read capture", 32'(rd_data), 32'(bus_rd));
        @(negedge clk); #1;
        check(astb_n == 1'b1, "R5 astb high mid T3", 32'(astb_n), 32'd1);
        if (!wr) check(rd_data == bus_rd, "R8 rd_data stable", 32'(rd_data), 32'(bus_rd));
        tick();
        check(done == 1'b0 && rw_o == 1'b1 && dstb_n == 1'b1, "R1 R4 after T3", {done, rw_o, dstb_n}, 32'b011);
        check({uben_n, lben_n} == ln[2:1] && addr_hi_o == addr[ADDR_W-1:16], "R3 lanes retained",
              {uben_n, lben_n, addr_hi_o}, {ln[2:1], addr[ADDR_W-1:16]});
        if (!hold_mid)
            check(ad_o == abus && ad_oe, "R3 address retained", {ad_oe, ad_o}, {1'b1, abus});
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'd1234));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check({astb_n, dstb_n, rw_o, hold_ack_n, wrl_n} == 5'b11111, "R5 R6 reset strobes",
              {astb_n, dstb_n, rw_o, hold_ack_n, wrl_n}, 32'h1f);
        check(done == 0 && req_ready == 1 && ctrl_oe == 1, "R1 reset state", {done, req_ready, ctrl_oe}, 32'b011);

        // directed corners
        do_access(24'h12_3456, 2'd2, 1'b0, 16'h0000, 4'd0, 16'hBEEF, 0);
        do_access(24'hA5_0002, 2'd1, 1'b1, 16'h1357, 4'd2, 16'h0000, 0);
        do_access(24'h00_0010, 2'd0, 1'b1, 16'h00AA, 4'd0, 16'h0000, 0);
        do_access(24'h00_0011, 2'd0, 1'b1, 16'hAA00, 4'd1, 16'h0000, 0);
        do_access(24'h7F_FFFF, 2'd0, 1'b0, 16'h0000, 4'd1, 16'hC3A5, 0);
        do_access(24'h33_8001, 2'd3, 1'b0, 16'h0000, 4'd15, 16'h5A5A, 0);
        repeat (3) tick();
        check(rw_o == 1 && astb_n == 1 && dstb_n == 1, "R4 R5 idle", {rw_o, astb_n, dstb_n}, 32'b111);

        // random accesses
        for (int k = 0; k < 40; k++) begin
            do_access(ADDR_W'($urandom), 2'($urandom % 4), 1'($urandom), 16'($urandom),
                      WAIT_W'($urandom % 6), 16'($urandom), 0);
            if (($urandom % 2) == 1) tick();
        end

        // hold while idle
        hold_req_n = 1'b0;
        cnt = 0;
        while (hold_ack_n && cnt < 10) begin tick(); cnt++; end
        check(cnt == 3, "R9 idle hold latency", 32'(cnt), 32'd3);
        check(!ctrl_oe && !ad_oe, "R9 outputs released", {ctrl_oe, ad_oe}, 32'b00);
        req_valid = 1'b1; req_size = 2'd2; req_write = 1'b1; req_waits = '0;
        cnt = 0;
        for (int k = 0; k < 5; k++) begin
            tick();
            if (hold_ack_n || !dstb_n || req_ready) cnt++;
        end
        check(cnt == 0, "R10 request stalled during hold", 32'(cnt), 32'd0);
        req_valid = 1'b0;
        hold_req_n = 1'b1;
        cnt = 0;
        while (!hold_ack_n && cnt < 10) begin tick(); cnt++; end
        check(cnt == 3, "R10 release latency", 32'(cnt), 32'd3);
        check(ctrl_oe && ad_oe && astb_n && dstb_n, "R10 driven before T1",
              {ctrl_oe, ad_oe, astb_n, dstb_n}, 32'hf);
        do_access(24'h44_0100, 2'd1, 1'b0, 16'h0, 4'd1, 16'h9876, 0);

        // hold arriving in the middle of an access
        do_access(24'h55_0203, 2'd0, 1'b1, 16'h00F0, 4'd3, 16'h0, 1);
        check(hold_ack_n == 1'b0 && !ctrl_oe && !ad_oe, "R9 hold right after T3",
              {hold_ack_n, ctrl_oe, ad_oe}, 32'b000);
        check(req_ready == 1'b0, "R10 not ready in hold", 32'(req_ready), 32'd0);
        hold_req_n = 1'b1;
        cnt = 0;
        while (!hold_ack_n && cnt < 10) begin tick(); cnt++; end
        check(cnt == 3 && ctrl_oe, "R10 release after mid hold", 32'(cnt), 32'd3);
        do_access(24'h55_0204, 2'd0, 1'b0, 16'h0, 4'd0, 16'h1122, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule